// File: doc/BRIEF.md
# Power-On Strap Capture and Frequency Source Select

This block sits between a row of shared configuration pins and the clock-generation core of a clock synthesizer. While power-on reset is held, the shared pins are inputs. Their levels are recorded on every clock edge at which reset is still asserted. The value from the last such edge becomes the strap word and holds until the next reset. Once reset has been released, the block turns on the output drivers of those same pins so that they can carry clock outputs. The recorded mode strap decides whether two further dual-purpose pins drive clocks (desktop) or act as asynchronous stop-request inputs (mobile).

The block also reads configuration byte 0 of a six-byte register image. That byte chooses whether the effective four-bit frequency code comes from the straps or from four register bits. It also supplies the spread-spectrum enable, the spread depth and a global output-disable control. The recorded frequency straps are merged into a readback copy of the register image at four read-only bit positions. Whatever the register image holds at those positions is ignored.

Top module: `strap_cfg_latch`

## Requirements
- R1: In the cycle after any clock edge that samples `por_n` low, `pad_oe`, `dual_oe`, `stop_req`, `freq_sel`, `spread_en`, `spread_wide` and `outs_hiz` are all 0.
- R2: `strap_word` equals the value of `pad_in` at the last rising edge that sampled `por_n` low, with bits [3:0] = frequency straps FS0..FS3 and bit 4 = mode strap. It stays unchanged while `por_n` is high, whatever `pad_in` does, including a change in the release cycle.
- R3: In the cycle after an edge that samples `por_n` high with byte 0 bit 0 clear, every bit of `pad_oe` is 1.
- R4: With mode strap 1, `dual_oe` is all ones after reset release and `stop_req` is 0. With mode strap 0, `dual_oe` is 0 and `stop_req[i]` equals the inverse of `dual_in[i]`, delayed by SYNC_STAGES (default 2) rising edges.
- R5: When byte 0 bit 3 (reg_img[3]) is 0, `freq_sel` equals strap bits [3:0], one cycle after the edge.
- R6: When byte 0 bit 3 is 1, `freq_sel` = {reg_img[2], reg_img[6], reg_img[5], reg_img[4]}, MSB first, one cycle after the edge.
- R7: `spread_en` follows reg_img[1] and `spread_wide` follows reg_img[7] (1 = ±0.6 %, 0 = ±0.25 %), one cycle after the edge.
- R8: When reg_img[0] is 1 after release, `outs_hiz` is 1 and both `pad_oe` and `dual_oe` are 0 one cycle later, including the first cycle after release.
- R9: `rd_img` equals `reg_img` except at four bits: bit 12 = FS0, bit 43 = FS1, bit 13 = FS2 and bit 23 = FS3. These carry the recorded straps (not inverted by default).
- R10: The values that `reg_img` holds at bits 12, 13, 23 and 43 change neither `rd_img` nor `freq_sel`.
- R11: A later reset pulse records new strap levels and replaces the old strap word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, sampled on `clk` |
| pad_in | input | 5 | Input levels of the shared strap pins (FS0..FS3, mode) |
| reg_img | input | 48 | Six-byte configuration image, byte 0 in bits [7:0] |
| dual_in | input | 2 | Input levels of the two dual-purpose pins |
| strap_word | output | 5 | Recorded strap levels |
| pad_oe | output | 5 | Output-driver enables of the shared strap pins |
| dual_oe | output | 2 | Output-driver enables of the dual-purpose pins |
| stop_req | output | 2 | Synchronised stop requests (mobile mode), active high |
| freq_sel | output | 4 | Effective frequency code |
| spread_en | output | 1 | Spread-spectrum enable |
| spread_wide | output | 1 | Spread depth: 1 = ±0.6 %, 0 = ±0.25 % |
| outs_hiz | output | 1 | All clock outputs to high impedance |
| rd_img | output | 48 | Readback image with strap bits merged in |

## Verification
Two events can land on the same edge. The release of reset can meet a configuration byte that already requests tristate and frequency override, and the strap pins can change level in the very cycle reset ends. The bench drives both conditions together: it releases `por_n`, moves `pad_in` on the same negative edge, and holds byte 0 with the override and disable bits set. It then requires the first post-release cycle to show the earlier strap word, drivers off and the register-chosen frequency code. A similar meeting in mobile mode is judged the same way. There the stop-pin synchroniser has been filled during reset, and the first `stop_req` after release must reflect pin levels seen while reset was asserted.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

   // byte-0 control bit positions
   localparam int B0_HIZ    = 0;
   localparam int B0_SPREAD = 1;
   localparam int B0_OVR    = 3;
   localparam int B0_DEPTH  = 7;

   // where each frequency strap appears in the readback image
   function automatic int rb_pos(input int fs_idx);
      case (fs_idx)
         0:       rb_pos = 12;
         1:       rb_pos = 43;
         2:       rb_pos = 13;
         default: rb_pos = 23;
      endcase
   endfunction

   // register-chosen frequency code, MSB first
   function automatic logic [3:0] ovr_code(input logic [7:0] b0);
      ovr_code = {b0[2], b0[6], b0[5], b0[4]};
   endfunction

endpackage

// File: rtl/ps_strap_capture.sv
module ps_strap_capture #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic [W-1:0] pad_in,
   output logic [W-1:0] strap_q
);

   // tracks pads during reset; last reset-edge value is kept
   always_ff @(posedge clk) begin
      if (!por_n) strap_q <= pad_in;
   end

endmodule

// File: rtl/ps_cfg_decode.sv
module ps_cfg_decode
   import strap_cfg_pkg::*;
#(
   parameter int FS_W      = 4,
   parameter int IMG_W     = 48,
   parameter bit RB_INVERT = 1'b0
) (
   input  logic [FS_W-1:0]  strap_fs,
   input  logic [IMG_W-1:0] reg_img,
   output logic [FS_W-1:0]  freq_nxt,
   output logic             spread_nxt,
   output logic             wide_nxt,
   output logic             hiz_nxt,
   output logic [IMG_W-1:0] rd_img
);

   logic [7:0]      b0;
   logic [FS_W-1:0] rb_bits;

   assign b0         = reg_img[7:0];
   assign freq_nxt   = b0[B0_OVR] ? ovr_code(b0) : strap_fs;
   assign spread_nxt = b0[B0_SPREAD];
   assign wide_nxt   = b0[B0_DEPTH];
   assign hiz_nxt    = b0[B0_HIZ];

   generate
      if (RB_INVERT) begin : g_rb_inv
         assign rb_bits = ~strap_fs;
      end else begin : g_rb_true
         assign rb_bits = strap_fs;
      end
   endgenerate

   always_comb begin
      rd_img = reg_img;
      for (int i = 0; i < FS_W; i++) rd_img[rb_pos(i)] = rb_bits[i];
   end

endmodule

// File: rtl/ps_pad_ctrl.sv
module ps_pad_ctrl #(
   parameter int N_PADS      = 5,
   parameter int N_DUAL      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              mode_desk,
   input  logic              hiz_nxt,
   input  logic [N_DUAL-1:0] dual_in,
   output logic [N_PADS-1:0] pad_oe,
   output logic [N_DUAL-1:0] dual_oe,
   output logic [N_DUAL-1:0] stop_req,
   output logic              outs_hiz
);

   logic              run_q;
   logic [N_DUAL-1:0] sync_q [SYNC_STAGES];

   always_ff @(posedge clk) sync_q[0] <= dual_in;

   generate
      for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
         always_ff @(posedge clk) sync_q[s] <= sync_q[s-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      run_q    <= por_n;
      outs_hiz <= por_n & hiz_nxt;
      pad_oe   <= (por_n && !hiz_nxt) ? '1 : '0;
      dual_oe  <= (por_n && !hiz_nxt && mode_desk) ? '1 : '0;
   end

   assign stop_req = (run_q && !mode_desk) ? ~sync_q[SYNC_STAGES-1] : '0;

endmodule

// File: rtl/strap_cfg_latch.sv
module strap_cfg_latch #(
   parameter int FS_W        = 4,
   parameter int N_DUAL      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int REG_BYTES   = 6,
   parameter bit RB_INVERT   = 1'b0
) (
   input  logic                   clk,
   input  logic                   por_n,
   input  logic [FS_W:0]          pad_in,
   input  logic [8*REG_BYTES-1:0] reg_img,
   input  logic [N_DUAL-1:0]      dual_in,
   output logic [FS_W:0]          strap_word,
   output logic [FS_W:0]          pad_oe,
   output logic [N_DUAL-1:0]      dual_oe,
   output logic [N_DUAL-1:0]      stop_req,
   output logic [FS_W-1:0]        freq_sel,
   output logic                   spread_en,
   output logic                   spread_wide,
   output logic                   outs_hiz,
   output logic [8*REG_BYTES-1:0] rd_img
);

   localparam int STRAP_W = FS_W + 1;
   localparam int IMG_W   = 8 * REG_BYTES;
   localparam int MODE_IX = FS_W;

   generate
      if (FS_W != 4) begin : g_bad_fs
         $error("strap_cfg_latch: FS_W must be 4");
      end
      if (REG_BYTES < 6) begin : g_bad_img
         $error("strap_cfg_latch: REG_BYTES must be at least 6");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("strap_cfg_latch: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [FS_W-1:0] freq_nxt;
   logic            spread_nxt, wide_nxt, hiz_nxt;

   ps_strap_capture #(.W(STRAP_W)) u_cap (
      .clk     (clk),
      .por_n   (por_n),
      .pad_in  (pad_in),
      .strap_q (strap_word)
   );

   ps_cfg_decode #(.FS_W(FS_W), .IMG_W(IMG_W), .RB_INVERT(RB_INVERT)) u_dec (
      .strap_fs   (strap_word[FS_W-1:0]),
      .reg_img    (reg_img),
      .freq_nxt   (freq_nxt),
      .spread_nxt (spread_nxt),
      .wide_nxt   (wide_nxt),
      .hiz_nxt    (hiz_nxt),
      .rd_img     (rd_img)
   );

   ps_pad_ctrl #(.N_PADS(STRAP_W), .N_DUAL(N_DUAL), .SYNC_STAGES(SYNC_STAGES)) u_pad (
      .clk       (clk),
      .por_n     (por_n),
      .mode_desk (strap_word[MODE_IX]),
      .hiz_nxt   (hiz_nxt),
      .dual_in   (dual_in),
      .pad_oe    (pad_oe),
      .dual_oe   (dual_oe),
      .stop_req  (stop_req),
      .outs_hiz  (outs_hiz)
   );

   always_ff @(posedge clk) begin
      if (!por_n) begin
         freq_sel    <= '0;
         spread_en   <= 1'b0;
         spread_wide <= 1'b0;
      end else begin
         freq_sel    <= freq_nxt;
         spread_en   <= spread_nxt;
         spread_wide <= wide_nxt;
      end
   end

endmodule

// File: rtl/strap_cfg_latch_chk.sv
module strap_cfg_latch_chk #(
   parameter int FS_W      = 4,
   parameter int N_DUAL    = 2,
   parameter int IMG_W     = 48,
   parameter bit RB_INVERT = 1'b0
) (
   input logic              clk,
   input logic              por_n,
   input logic [IMG_W-1:0]  reg_img,
   input logic [FS_W:0]     strap_word,
   input logic [FS_W:0]     pad_oe,
   input logic [N_DUAL-1:0] dual_oe,
   input logic [N_DUAL-1:0] stop_req,
   input logic [FS_W-1:0]   freq_sel,
   input logic              outs_hiz,
   input logic [IMG_W-1:0]  rd_img
);

   logic past_valid = 1'b0;
   always_ff @(posedge clk) past_valid <= 1'b1;

   a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (!past_valid)
      !por_n |=> (pad_oe == '0 && dual_oe == '0 && stop_req == '0 && !outs_hiz));

   a_r2_strap_hold: assert property (@(posedge clk) disable iff (!por_n)
      por_n |=> $stable(strap_word));

   a_r4_desktop_no_stop: assert property (@(posedge clk) disable iff (!por_n)
      strap_word[FS_W] |-> stop_req == '0);

   a_r5_strap_freq: assert property (@(posedge clk) disable iff (!por_n)
      (por_n && !reg_img[3]) |=> freq_sel == $past(strap_word[FS_W-1:0]));

   a_r8_hiz_no_drive: assert property (@(posedge clk) disable iff (!por_n)
      outs_hiz |-> (pad_oe == '0 && dual_oe == '0));

   a_r9_readback: assert property (@(posedge clk) disable iff (!por_n)
      (rd_img[12] == (strap_word[0] ^ RB_INVERT)) && (rd_img[43] == (strap_word[1] ^ RB_INVERT)) &&
      (rd_img[13] == (strap_word[2] ^ RB_INVERT)) && (rd_img[23] == (strap_word[3] ^ RB_INVERT)));

endmodule

bind strap_cfg_latch strap_cfg_latch_chk #(
   .FS_W(FS_W), .N_DUAL(N_DUAL), .IMG_W(8*REG_BYTES), .RB_INVERT(RB_INVERT)
) u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .reg_img    (reg_img),
   .strap_word (strap_word),
   .pad_oe     (pad_oe),
   .dual_oe    (dual_oe),
   .stop_req   (stop_req),
   .freq_sel   (freq_sel),
   .outs_hiz   (outs_hiz),
   .rd_img     (rd_img)
);

// File: tb/strap_cfg_latch_tb.sv
module strap_cfg_latch_tb;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [7:0] b0;
      logic [3:0] f;
      logic       sp;
      logic       w;
      logic       hz;
   } vec_t;

   // straps during the table walk: FS = 4'b1010, desktop mode
   localparam vec_t VECS [8] = '{
      '{8'h00, 4'hA, 1'b0, 1'b0, 1'b0},
      '{8'h08, 4'h0, 1'b0, 1'b0, 1'b0},
      '{8'h5C, 4'hD, 1'b0, 1'b0, 1'b0},
      '{8'h2A, 4'h2, 1'b1, 1'b0, 1'b0},
      '{8'h82, 4'hA, 1'b1, 1'b1, 1'b0},
      '{8'h01, 4'hA, 1'b0, 1'b0, 1'b1},
      '{8'h74, 4'hA, 1'b0, 1'b0, 1'b0},
      '{8'hFF, 4'hF, 1'b1, 1'b1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        por_n;
   logic [4:0]  pad_in;
   logic [47:0] reg_img;
   logic [1:0]  dual_in;
   logic [4:0]  strap_word, pad_oe;
   logic [1:0]  dual_oe, stop_req;
   logic [3:0]  freq_sel;
   logic        spread_en, spread_wide, outs_hiz;
   logic [47:0] rd_img;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   strap_cfg_latch u_dut (
      .clk(clk), .por_n(por_n), .pad_in(pad_in), .reg_img(reg_img), .dual_in(dual_in),
      .strap_word(strap_word), .pad_oe(pad_oe), .dual_oe(dual_oe), .stop_req(stop_req),
      .freq_sel(freq_sel), .spread_en(spread_en), .spread_wide(spread_wide),
      .outs_hiz(outs_hiz), .rd_img(rd_img)
   );

   task automatic chk(input string tag, input logic [47:0] got, input logic [47:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic quiet(input string tag);
      chk({tag, " pad_oe"},   48'(pad_oe),   48'h0);
      chk({tag, " dual_oe"},  48'(dual_oe),  48'h0);
      chk({tag, " stop_req"}, 48'(stop_req), 48'h0);
      chk({tag, " freq"},     48'(freq_sel), 48'h0);
      chk({tag, " spread"},   48'({spread_en, spread_wide, outs_hiz}), 48'h0);
   endtask

   logic [47:0] exp_img;

   initial begin
      por_n   = 1'b0;
      pad_in  = 5'b1_1010;
      reg_img = 48'h0;
      dual_in = 2'b11;
      step(3);
      quiet("R1 reset");
      chk("R2 capture", 48'(strap_word), 48'h1A);

      // release with pads moving in the same cycle
      por_n  = 1'b1;
      pad_in = 5'b0_0101;
      step(1);
      chk("R2 release hold", 48'(strap_word), 48'h1A);
      chk("R3 pad_oe on",    48'(pad_oe),     48'h1F);
      chk("R4 desktop oe",   48'(dual_oe),    48'h3);
      chk("R4 desktop stop", 48'(stop_req),   48'h0);
      chk("R5 strap freq",   48'(freq_sel),   48'hA);

      // table walk over byte 0 (R5..R8)
      for (int i = 0; i < 8; i++) begin
         reg_img[7:0] = VECS[i].b0;
         pad_in = ~pad_in;
         step(1);
         chk("R5/R6 freq_sel",  48'(freq_sel),    48'(VECS[i].f));
         chk("R7 spread_en",    48'(spread_en),   48'(VECS[i].sp));
         chk("R7 spread_wide",  48'(spread_wide), 48'(VECS[i].w));
         chk("R8 outs_hiz",     48'(outs_hiz),    48'(VECS[i].hz));
         chk("R8 pad_oe",       48'(pad_oe),      VECS[i].hz ? 48'h0 : 48'h1F);
         chk("R8 dual_oe",      48'(dual_oe),     VECS[i].hz ? 48'h0 : 48'h3);
         chk("R2 strap stable", 48'(strap_word),  48'h1A);
      end

      // readback merge, strap FS0=0 FS1=1 FS2=0 FS3=1
      reg_img = 48'hFFFF_FFFF_FF00;
      step(1);
      exp_img = reg_img;
      exp_img[12] = 1'b0; exp_img[43] = 1'b1; exp_img[13] = 1'b0; exp_img[23] = 1'b1;
      chk("R9 readback ones",  rd_img, exp_img);
      chk("R10 freq ignores",  48'(freq_sel), 48'hA);
      reg_img = 48'h0;
      step(1);
      exp_img = 48'h0;
      exp_img[43] = 1'b1; exp_img[23] = 1'b1;
      chk("R10 readback zeros", rd_img, exp_img);

      // second reset into mobile mode
      por_n   = 1'b0;
      pad_in  = 5'b0_0110;
      step(2);
      quiet("R1 re-reset");
      por_n = 1'b1;
      step(1);
      chk("R11 recapture",  48'(strap_word), 48'h06);
      chk("R4 mobile oe",   48'(dual_oe),    48'h0);
      chk("R3 pad_oe",      48'(pad_oe),     48'h1F);
      chk("R5 new freq",    48'(freq_sel),   48'h6);
      chk("R4 no stop",     48'(stop_req),   48'h0);
      dual_in = 2'b01;
      step(1);
      chk("R4 sync latency", 48'(stop_req),  48'h0);
      step(1);
      chk("R4 stop pin1",    48'(stop_req),  48'h2);
      reg_img[7:0] = 8'h01;
      step(1);
      chk("R8 mobile hiz",   48'({pad_oe, dual_oe}), 48'h0);

      // release coinciding with tristate and override
      por_n   = 1'b0;
      pad_in  = 5'b1_0011;
      reg_img[7:0] = 8'h19;
      step(2);
      quiet("R1 third reset");
      por_n  = 1'b1;
      pad_in = 5'b0_1100;
      step(1);
      chk("R2 same-cycle strap", 48'(strap_word), 48'h13);
      chk("R8 first-cycle hiz",  48'(outs_hiz),   48'h1);
      chk("R8 first-cycle oe",   48'({pad_oe, dual_oe}), 48'h0);
      chk("R6 first-cycle freq", 48'(freq_sel),   48'h1);
      reg_img[7:0] = 8'h00;
      step(1);
      chk("R3 drivers back",   48'(pad_oe),   48'h1F);
      chk("R4 desktop again",  48'(dual_oe),  48'h3);
      chk("R5 strap freq 3",   48'(freq_sel), 48'h3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog got=hung exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule